// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Register

This block is the status and control register of one serial channel. It gathers event strobes from a separate receive and transmit datapath and holds them as sticky flags: receive data full, transmit data empty, and the parity, framing and overrun errors. The CPU can read all of these flags but cannot write any of them. The same byte also holds three CPU-writable control bits: a receive interrupt enable, a transmit interrupt enable and a bit-order select. The bit-order select is passed to the shifter. The two interrupt request lines are formed from the flags and the enables.

The flags are cleared only by their own events. A read of the received-data register clears receive data full. A write of transmit data clears transmit data empty. The three error flags are cleared by a strobe that comes from the receiver-clear control held in another register. If a set and a clear reach the same flag in the same cycle, the set wins, so no event is lost. All flags update on the clock edge that samples the strobe. Read data and the interrupt lines follow in the same cycle from the registered state.

Top module: `uart_stat_reg`

## Requirements
- R1: After synchronous reset the status byte reads 8'h08: only transmit data empty is 1. The bit-order output and both interrupt lines are 0.
- R2: The status byte has this layout: bit7 parity error, bit6 overrun, bit5 framing error, bit4 receive data full, bit3 transmit data empty, bit2 bit order, bit1 receive interrupt enable, bit0 transmit interrupt enable. A CPU write loads bits 2:0 from the write data at the next edge. `bit_order_o` equals bit2, where 0 means LSB first and 1 means MSB first.
- R3: A CPU write has no effect on bits 7:3.
- R4: A parity strobe sets bit7. A framing strobe sets bit5.
- R5: A frame-done strobe sets bit4. A read strobe of the received-data register clears bit4.
- R6: A frame-done strobe that arrives while bit4 is already 1 sets bit6.
- R7: The error-clear strobe clears bits 7, 6 and 5. It leaves bit4 unchanged.
- R8: A transmit-data write strobe clears bit3. A transmitter load strobe sets bit3.
- R9: When a flag's set event and clear event occur in the same cycle, the flag becomes 1.
- R10: `rx_irq_o` is 1 exactly when bit1 is 1 and at least one of bits 7 to 4 is 1.
- R11: `tx_irq_o` is 1 exactly when bit0 is 1 and bit3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done_i | input | 1 | Receiver completed a frame |
| rx_par_err_i | input | 1 | Received frame had a parity error |
| rx_frm_err_i | input | 1 | Received frame had a framing error |
| err_clr_i | input | 1 | Receiver-clear strobe from the mode register |
| rdata_rd_i | input | 1 | CPU read of the received-data register |
| tdata_wr_i | input | 1 | CPU write of the transmit-data register |
| tx_load_i | input | 1 | Transmitter moved the data into its shifter |
| cpu_wr_i | input | 1 | CPU write to this register |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Status byte |
| bit_order_o | output | 1 | 0 LSB first, 1 MSB first |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |

## Verification
Every flag is visible on the read port one cycle after its event. A flag stuck high, a lost set, or a wrong choice when set and clear collide therefore shows up in the next sampled read. An interrupt line that is gated wrongly differs from the value expected from the flags and enables in that same cycle. The error-clear path and the overrun path depend on the state of receive data full, so the bench drives these strobes in random combinations with rare clears. This lets collisions and back-to-back frames occur often.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

  localparam int STAT_W = 8;
  localparam int CTRL_W = 3;
  localparam int ERR_N  = 3;

  // bit positions in the status byte
  localparam int B_PE   = 7;
  localparam int B_ORE  = 6;
  localparam int B_FRE  = 5;
  localparam int B_RDRF = 4;
  localparam int B_TDRE = 3;

  // positions inside the error bank
  localparam int E_PE  = 2;
  localparam int E_ORE = 1;
  localparam int E_FRE = 0;

  // positions inside the control field
  localparam int C_ORD = 2;
  localparam int C_RIE = 1;
  localparam int C_TIE = 0;

  typedef struct packed {
    logic [ERR_N-1:0]  err;
    logic              rdrf;
    logic              tdre;
    logic [CTRL_W-1:0] ctrl;
  } stat_t;

  // set wins over clear
  function automatic logic flag_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic rx_req(logic [ERR_N-1:0] err, logic rdrf, logic rie);
    return rie & (rdrf | (|err));
  endfunction

  function automatic logic tx_req(logic tdre, logic tie);
    return tie & tdre;
  endfunction

  function automatic logic [STAT_W-1:0] pack_stat(stat_t s);
    return {s.err, s.rdrf, s.tdre, s.ctrl};
  endfunction

endpackage

// File: rtl/ustat_flag.sv
module ustat_flag
  import uart_stat_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= flag_next(q, set_i, clr_i);
  end

  assign q_o = q;

endmodule

// File: rtl/ustat_err_bank.sv
module ustat_err_bank
  import uart_stat_pkg::*;
#(
  parameter int N = ERR_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_err
    ustat_flag #(.RST_VAL(1'b0)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_i[i]),
      .clr_i (clr_i),
      .q_o   (q_o[i])
    );
  end

endmodule

// File: rtl/ustat_ctrl.sv
module ustat_ctrl
  import uart_stat_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (we_i) q <= d_i;
  end

  assign q_o = q;

endmodule

// File: rtl/ustat_irq.sv
module ustat_irq
  import uart_stat_pkg::*;
(
  input  logic [ERR_N-1:0] err_i,
  input  logic             rdrf_i,
  input  logic             tdre_i,
  input  logic             rie_i,
  input  logic             tie_i,
  output logic             rx_irq_o,
  output logic             tx_irq_o
);

  assign rx_irq_o = rx_req(err_i, rdrf_i, rie_i);
  assign tx_irq_o = tx_req(tdre_i, tie_i);

endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
  import uart_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done_i,
  input  logic              rx_par_err_i,
  input  logic              rx_frm_err_i,
  input  logic              err_clr_i,
  input  logic              rdata_rd_i,
  input  logic              tdata_wr_i,
  input  logic              tx_load_i,
  input  logic              cpu_wr_i,
  input  logic [STAT_W-1:0] cpu_wdata_i,
  output logic [STAT_W-1:0] cpu_rdata_o,
  output logic              bit_order_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);

  // named internal events, observed by the checker
  logic              ovr_set;
  logic [ERR_N-1:0]  err_set;
  logic [ERR_N-1:0]  err_q;
  logic              rdrf_q;
  logic              tdre_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              unused_wbits;
  stat_t             stat;

  assign ovr_set = rx_done_i & rdrf_q;

  always_comb begin
    err_set        = '0;
    err_set[E_PE]  = rx_par_err_i;
    err_set[E_ORE] = ovr_set;
    err_set[E_FRE] = rx_frm_err_i;
  end

  ustat_err_bank #(.N(ERR_N)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (err_set),
    .clr_i (err_clr_i),
    .q_o   (err_q)
  );

  ustat_flag #(.RST_VAL(1'b0)) u_rdrf (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (rx_done_i),
    .clr_i (rdata_rd_i),
    .q_o   (rdrf_q)
  );

  ustat_flag #(.RST_VAL(1'b1)) u_tdre (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (tx_load_i),
    .clr_i (tdata_wr_i),
    .q_o   (tdre_q)
  );

  ustat_ctrl #(.W(CTRL_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (cpu_wr_i),
    .d_i   (cpu_wdata_i[CTRL_W-1:0]),
    .q_o   (ctrl_q)
  );

  assign unused_wbits = ^cpu_wdata_i[STAT_W-1:CTRL_W];

  ustat_irq u_irq (
    .err_i    (err_q),
    .rdrf_i   (rdrf_q),
    .tdre_i   (tdre_q),
    .rie_i    (ctrl_q[C_RIE]),
    .tie_i    (ctrl_q[C_TIE]),
    .rx_irq_o (rx_irq_o),
    .tx_irq_o (tx_irq_o)
  );

  assign stat.err  = err_q;
  assign stat.rdrf = rdrf_q;
  assign stat.tdre = tdre_q;
  assign stat.ctrl = ctrl_q;

  assign cpu_rdata_o = pack_stat(stat);
  assign bit_order_o = ctrl_q[C_ORD];

endmodule

// File: rtl/ustat_chk.sv
module ustat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_done_i,
  input logic       rx_par_err_i,
  input logic       rx_frm_err_i,
  input logic       err_clr_i,
  input logic       rdata_rd_i,
  input logic       tdata_wr_i,
  input logic       tx_load_i,
  input logic       cpu_wr_i,
  input logic       ovr_set,
  input logic [7:0] cpu_rdata_o,
  input logic       bit_order_o,
  input logic       rx_irq_o,
  input logic       tx_irq_o
);

  logic quiet;
  assign quiet = !(rx_done_i | rx_par_err_i | rx_frm_err_i | err_clr_i |
                   rdata_rd_i | tdata_wr_i | tx_load_i);

  // R2
  order_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_order_o == cpu_rdata_o[2]);

  // R3
  ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_i && quiet |=> $stable(cpu_rdata_o[7:3]));

  // R4
  par_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_par_err_i |=> cpu_rdata_o[7]);

  // R4
  frm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frm_err_i |=> cpu_rdata_o[5]);

  // R5
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> cpu_rdata_o[4]);

  // R5
  full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_rd_i && !rx_done_i |=> !cpu_rdata_o[4]);

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i && cpu_rdata_o[4] |=> cpu_rdata_o[6]);

  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_i && !rx_par_err_i && !rx_frm_err_i && !ovr_set |=>
      cpu_rdata_o[7:5] == 3'b000);

  // R7
  clr_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_i && !rdata_rd_i && cpu_rdata_o[4] |=> cpu_rdata_o[4]);

  // R8
  tx_empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tdata_wr_i && !tx_load_i |=> !cpu_rdata_o[3]);

  // R9
  tx_empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_i |=> cpu_rdata_o[3]);

  // R10
  rx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdata_o[1] |-> !rx_irq_o);

  // R10
  rx_irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata_o[1] && (cpu_rdata_o[7:4] != 4'b0) |-> rx_irq_o);

  // R11
  tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_o == (cpu_rdata_o[0] && cpu_rdata_o[3]));

endmodule

bind uart_stat_reg ustat_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_done_i    (rx_done_i),
  .rx_par_err_i (rx_par_err_i),
  .rx_frm_err_i (rx_frm_err_i),
  .err_clr_i    (err_clr_i),
  .rdata_rd_i   (rdata_rd_i),
  .tdata_wr_i   (tdata_wr_i),
  .tx_load_i    (tx_load_i),
  .cpu_wr_i     (cpu_wr_i),
  .ovr_set      (ovr_set),
  .cpu_rdata_o  (cpu_rdata_o),
  .bit_order_o  (bit_order_o),
  .rx_irq_o     (rx_irq_o),
  .tx_irq_o     (tx_irq_o)
);

// File: tb/tb_uart_stat_reg.sv
`timescale 1ns/1ps
module tb_uart_stat_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 0, par = 0, frm = 0, clr = 0, rd = 0, twr = 0, tld = 0, wr = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       bord, rxirq, txirq;
  logic [7:0] exp_q = 8'h08;
  int         n_run = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_stat_reg dut (
    .clk(clk), .rst_n(rst_n),
    .rx_done_i(rxd), .rx_par_err_i(par), .rx_frm_err_i(frm),
    .err_clr_i(clr), .rdata_rd_i(rd), .tdata_wr_i(twr), .tx_load_i(tld),
    .cpu_wr_i(wr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .bit_order_o(bord),
    .rx_irq_o(rxirq), .tx_irq_o(txirq)
  );

  // model of the status byte, written bit by bit from the requirements
  function automatic logic [7:0] model_next(logic [7:0] s);
    logic [7:0] n;
    n[7] = par ? 1'b1 : (clr ? 1'b0 : s[7]);
    n[6] = (rxd && s[4]) ? 1'b1 : (clr ? 1'b0 : s[6]);
    n[5] = frm ? 1'b1 : (clr ? 1'b0 : s[5]);
    n[4] = rxd ? 1'b1 : (rd ? 1'b0 : s[4]);
    n[3] = tld ? 1'b1 : (twr ? 1'b0 : s[3]);
    n[2:0] = wr ? wdata[2:0] : s[2:0];
    return n;
  endfunction

  function automatic logic model_rx_irq(logic [7:0] s);
    return s[1] && (s[7] || s[6] || s[5] || s[4]);
  endfunction

  function automatic logic model_tx_irq(logic [7:0] s);
    return s[0] && s[3];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 status"}, rdata, exp_q);
    chk({tag, " R2 order"}, {7'b0, bord}, {7'b0, exp_q[2]});
    chk({tag, " R10 rxirq"}, {7'b0, rxirq}, {7'b0, model_rx_irq(exp_q)});
    chk({tag, " R11 txirq"}, {7'b0, txirq}, {7'b0, model_tx_irq(exp_q)});
  endtask

  task automatic idle_in();
    rxd = 0; par = 0; frm = 0; clr = 0; rd = 0; twr = 0; tld = 0; wr = 0; wdata = '0;
  endtask

  // one cycle: inputs are already set at a falling edge
  task automatic cyc(string tag);
    exp_q = model_next(exp_q);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    idle_in();
  endtask

  initial begin
    int lim = 0;
    while (lim < 100000) begin
      @(posedge clk);
      lim++;
    end
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", lim, 100000);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 reset status", rdata, 8'h08);
    chk("R1 reset outputs", {5'b0, bord, rxirq, txirq}, 8'h00);

    wr = 1; wdata = 8'hFF; cyc("R3 write");
    chk("R3 upper bits ignored", rdata, 8'h0F);
    chk("R11 tx irq on", {7'b0, txirq}, 8'h01);

    rxd = 1; cyc("R5 frame");
    chk("R5 full set", rdata, 8'h1F);
    chk("R10 rx irq on", {7'b0, rxirq}, 8'h01);

    rxd = 1; cyc("R6 overrun");
    chk("R6 overrun set", rdata, 8'h5F);

    rd = 1; cyc("R5 read");
    chk("R5 full cleared", rdata, 8'h4F);

    par = 1; frm = 1; cyc("R4 errors");
    chk("R4 parity and framing set", rdata, 8'hEF);

    clr = 1; cyc("R7 clear");
    chk("R7 errors cleared", rdata, 8'h0F);
    chk("R10 rx irq off", {7'b0, rxirq}, 8'h00);

    rxd = 1; cyc("R7 prep");
    clr = 1; cyc("R7 keep full");
    chk("R7 full kept", rdata, 8'h1F);
    rd = 1; cyc("R5 read2");

    par = 1; clr = 1; cyc("R9 err collide");
    chk("R9 parity wins", rdata, 8'h8F);

    twr = 1; cyc("R8 tx write");
    chk("R8 empty cleared", rdata, 8'h87);
    chk("R11 tx irq off", {7'b0, txirq}, 8'h00);

    twr = 1; tld = 1; cyc("R9 tx collide");
    chk("R9 empty wins", rdata, 8'h8F);

    rxd = 1; rd = 1; cyc("R9 rx collide");
    chk("R9 full wins", rdata, 8'h9F);

    wr = 1; wdata = 8'hF8; cyc("R2 write zero");
    chk("R2 ctrl cleared", rdata, 8'h98);
    chk("R10 gated", {6'b0, rxirq, txirq}, 8'h00);

    wr = 1; wdata = 8'h04; cyc("R2 msb first");
    chk("R2 order out", {7'b0, bord}, 8'h01);

    for (int i = 0; i < 3000; i++) begin
      rxd = ($urandom_range(0, 99) < 25);
      par = ($urandom_range(0, 99) < 8);
      frm = ($urandom_range(0, 99) < 8);
      clr = ($urandom_range(0, 99) < 10);
      rd  = ($urandom_range(0, 99) < 25);
      twr = ($urandom_range(0, 99) < 25);
      tld = ($urandom_range(0, 99) < 25);
      wr  = ($urandom_range(0, 99) < 10);
      wdata = 8'($urandom());
      cyc("R4 R5 R6 R7 R8 R9 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule